// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the host side of an SMBus controller as software sees it through a byte-wide register port. Software loads a target address, a command byte and up to two data bytes. For block transfers it also streams up to 32 bytes through a single data port into an internal buffer. It then writes the control register with the start bit set.

A sequencer then drives a byte-level link engine through one of five transaction shapes. The link engine takes requests to send a start condition with an address byte, write a byte, read a byte, or send a stop condition. It answers each request with a done pulse, an acknowledge flag and an arbitration-loss flag. When the transaction ends, the outcome is left in sticky status bits that software clears by writing ones.

The link handshake works as follows. `lnk_req` is held high with `lnk_op`, `lnk_wbyte` and `lnk_last` stable until the link engine pulses `lnk_done` for one cycle. `lnk_ack` and `lnk_lost` are sampled in that same cycle. For reads, `lnk_rbyte` is also sampled in that cycle.

Top module: `smb_host_seq`

## Requirements
- R1: A register write to offset 2 with bit 6 set starts a transaction whose type is bits 4:2 of the written byte. Status bit 0 (busy) reads 1 from the cycle after that write until the transaction ends. A start written while busy is ignored.
- R2: Status bit 1 (done) is set only when a transaction ends with no error. It stays set until a write to offset 0 has bit 1 set. Writing 0 to that bit leaves it unchanged.
- R3: Status bit 2 is set when a start or write request is not acknowledged, and a stop is then issued. Status bit 3 is set when arbitration is lost, and the transaction ends with no further request. Status bit 4 marks a failed transaction. All three are sticky and are cleared by writing 1 to their position.
- R4: The address register (offset 4) carries the 7-bit target in bits 7:1 and the direction in bit 0, where 1 means read. Quick and byte transfers send the register unchanged in their start. Other types send bits 7:1 with bit 0 cleared first, and read types then send a repeated start with bit 0 set.
- R5: Link op codes are 0 start, 1 write, 2 read and 3 stop. A quick transfer (type 000) issues a start and then a stop.
- R6: A byte transfer (type 001) issues start, then write of the command byte (offset 3), then stop when writing. When reading it issues start, then one read marked last, then stop, and the read byte is placed in data0 (offset 5). `lnk_last` is high only on the final read of a transaction.
- R7: Byte-data (010) and word-data (011) transfers send start and the command byte before the data phase. Data0 holds the low byte and data1 (offset 6) holds the high byte, in both directions.
- R8: A block write (type 101, direction 0) sends start, command, the count from data0 and then that many buffer bytes, then stop. A count of 0 or above 32 sets status bit 4 with no link request.
- R9: A block read reads a count byte into data0 and then that many bytes into the buffer. A received count of 0 or above 32 sets status bit 4 and goes straight to stop.
- R10: A read of offset 2 resets the block buffer index to 0. Each later read of offset 7, and each write to offset 7 while idle, accesses the buffer at the index and then advances it by one.
- R11: Type codes 100, 110 and 111 end at once with status bit 4 set and no link request.
- R12: While busy, writes to the address, command, data0, data1, control and block-data registers are ignored.
- R13: Status reads as {3'b0, failed, collision, no-ack, done, busy}. Control reads back its last written value with bit 6 as 0. Offset 1 reads 0. After reset all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| lnk_req | output | 1 | Link request valid, held until done |
| lnk_op | output | 2 | Link op: 0 start, 1 write, 2 read, 3 stop |
| lnk_wbyte | output | 8 | Byte to send (address byte for start) |
| lnk_last | output | 1 | Final read of the transaction (host NACKs) |
| lnk_done | input | 1 | Link request finished (one-cycle pulse) |
| lnk_ack | input | 1 | Byte acknowledged by target |
| lnk_lost | input | 1 | Arbitration lost during request |
| lnk_rbyte | input | 8 | Byte received on a read |

## Verification
A wrong sequencer state shows at the link port on the very next request: a wrong op code, a start byte with the wrong direction bit, or a missing repeated start. The bench compares every accepted request against its expected list as soon as the request appears. A wrong buffer index or count shows only when software later streams the block port or reads data0, so those reads follow each block transfer directly. Status bits that are dropped, or set where they should not be, show on the first status poll after busy falls.

// File: rtl/smb_host_seq.sv
module smb_host_seq #(
  parameter int BUF_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       lnk_req,
  output logic [1:0] lnk_op,
  output logic [7:0] lnk_wbyte,
  output logic       lnk_last,
  input  logic       lnk_done,
  input  logic       lnk_ack,
  input  logic       lnk_lost,
  input  logic [7:0] lnk_rbyte
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam logic [2:0] T_QUICK = 3'b000, T_BYTE = 3'b001, T_BDATA = 3'b010,
                         T_WORD = 3'b011, T_BLOCK = 3'b101;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_RADDR, S_WD0, S_WD1, S_WCNT, S_WBLK,
    S_RD0, S_RD1, S_RCNT, S_RBLK, S_STOP, S_FIN
  } st_t;

  st_t state, nxt;
  logic [7:0] ctrl_q, cmd_q, addr_q, data0_q, data1_q;
  logic [7:0] bcnt;
  logic [IDX_W-1:0] idx, idx_inc;
  logic [7:0] buf_q [BUF_DEPTH];
  logic sts_done, sts_nack, sts_coll, sts_fail, err_seen;
  logic set_nack, set_coll, set_fail;

  wire busy     = (state != S_IDLE);
  wire [2:0] ty = ctrl_q[4:2];
  wire rd_dir   = addr_q[0];
  wire go       = reg_wr && reg_addr == 3'd2 && reg_wdata[6] && !busy;
  wire sts_wr   = reg_wr && reg_addr == 3'd0;
  wire cfg_wr   = reg_wr && !busy;
  wire cnt_ok   = (data0_q != 8'd0) && (int'(data0_q) <= BUF_DEPTH);
  wire rcnt_ok  = (lnk_rbyte != 8'd0) && (int'(lnk_rbyte) <= BUF_DEPTH);
  wire last_blk = (bcnt == data0_q - 8'd1);
  wire in_blk   = (state == S_WBLK) || (state == S_RBLK);
  wire ack_chk  = (state == S_ADDR) || (state == S_CMD) || (state == S_RADDR) ||
                  (state == S_WD0) || (state == S_WD1) || (state == S_WCNT) ||
                  (state == S_WBLK);
  wire take     = lnk_done && !lnk_lost;

  assign idx_inc = (idx == IDX_W'(BUF_DEPTH - 1)) ? '0 : idx + 1'b1;

  always_comb begin
    nxt = state;
    set_nack = 1'b0;
    set_coll = 1'b0;
    set_fail = 1'b0;
    case (state)
      S_IDLE: if (go) begin
        case (reg_wdata[4:2])
          T_QUICK, T_BYTE, T_BDATA, T_WORD: nxt = S_ADDR;
          T_BLOCK: begin
            if (addr_q[0] || cnt_ok) nxt = S_ADDR;
            else begin nxt = S_FIN; set_fail = 1'b1; end
          end
          default: begin nxt = S_FIN; set_fail = 1'b1; end
        endcase
      end
      S_FIN: nxt = S_IDLE;
      default: if (lnk_done) begin
        if (lnk_lost) begin
          set_coll = 1'b1;
          nxt = S_FIN;
        end else if (ack_chk && !lnk_ack) begin
          set_nack = 1'b1;
          nxt = S_STOP;
        end else begin
          case (state)
            S_ADDR:  nxt = (ty == T_QUICK) ? S_STOP :
                           (ty == T_BYTE && rd_dir) ? S_RD0 : S_CMD;
            S_CMD:   nxt = (ty == T_BYTE) ? S_STOP : rd_dir ? S_RADDR :
                           (ty == T_BLOCK) ? S_WCNT : S_WD0;
            S_RADDR: nxt = (ty == T_BLOCK) ? S_RCNT : S_RD0;
            S_WD0:   nxt = (ty == T_WORD) ? S_WD1 : S_STOP;
            S_WD1:   nxt = S_STOP;
            S_WCNT:  nxt = S_WBLK;
            S_WBLK:  nxt = last_blk ? S_STOP : S_WBLK;
            S_RD0:   nxt = (ty == T_WORD) ? S_RD1 : S_STOP;
            S_RD1:   nxt = S_STOP;
            S_RCNT: begin
              if (rcnt_ok) nxt = S_RBLK;
              else begin nxt = S_STOP; set_fail = 1'b1; end
            end
            S_RBLK:  nxt = last_blk ? S_STOP : S_RBLK;
            default: nxt = S_FIN;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ctrl_q <= '0; cmd_q <= '0; addr_q <= '0; data0_q <= '0; data1_q <= '0;
      bcnt <= '0; idx <= '0; err_seen <= 1'b0;
      sts_done <= 1'b0; sts_nack <= 1'b0; sts_coll <= 1'b0; sts_fail <= 1'b0;
    end else begin
      state <= nxt;
      if (cfg_wr && reg_addr == 3'd2) ctrl_q <= {reg_wdata[7], 1'b0, reg_wdata[5:0]};
      if (cfg_wr && reg_addr == 3'd3) cmd_q <= reg_wdata;
      if (cfg_wr && reg_addr == 3'd4) addr_q <= reg_wdata;
      if (cfg_wr && reg_addr == 3'd5) data0_q <= reg_wdata;
      else if (take && (state == S_RD0 || state == S_RCNT)) data0_q <= lnk_rbyte;
      if (cfg_wr && reg_addr == 3'd6) data1_q <= reg_wdata;
      else if (take && state == S_RD1) data1_q <= lnk_rbyte;
      if (!in_blk) bcnt <= '0;
      else if (take) bcnt <= bcnt + 8'd1;
      if (reg_rd && reg_addr == 3'd2) idx <= '0;
      else if ((reg_rd || cfg_wr) && reg_addr == 3'd7) idx <= idx_inc;
      if (go) err_seen <= set_fail;
      else if (set_nack || set_coll || set_fail) err_seen <= 1'b1;
      if (state == S_FIN && !err_seen) sts_done <= 1'b1;
      else if (sts_wr && reg_wdata[1]) sts_done <= 1'b0;
      if (set_nack) sts_nack <= 1'b1;
      else if (sts_wr && reg_wdata[2]) sts_nack <= 1'b0;
      if (set_coll) sts_coll <= 1'b1;
      else if (sts_wr && reg_wdata[3]) sts_coll <= 1'b0;
      if (set_fail) sts_fail <= 1'b1;
      else if (sts_wr && reg_wdata[4]) sts_fail <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_wr && reg_addr == 3'd7) buf_q[idx] <= reg_wdata;
    else if (take && state == S_RBLK) buf_q[bcnt[IDX_W-1:0]] <= lnk_rbyte;
  end

  assign lnk_req = busy && state != S_FIN;

  always_comb begin
    case (state)
      S_ADDR, S_RADDR:                        lnk_op = 2'd0;
      S_CMD, S_WD0, S_WD1, S_WCNT, S_WBLK:    lnk_op = 2'd1;
      S_RD0, S_RD1, S_RCNT, S_RBLK:           lnk_op = 2'd2;
      default:                                lnk_op = 2'd3;
    endcase
    case (state)
      S_ADDR:        lnk_wbyte = (ty == T_QUICK || ty == T_BYTE) ? addr_q : {addr_q[7:1], 1'b0};
      S_RADDR:       lnk_wbyte = {addr_q[7:1], 1'b1};
      S_CMD:         lnk_wbyte = cmd_q;
      S_WD0, S_WCNT: lnk_wbyte = data0_q;
      S_WD1:         lnk_wbyte = data1_q;
      S_WBLK:        lnk_wbyte = buf_q[bcnt[IDX_W-1:0]];
      default:       lnk_wbyte = 8'd0;
    endcase
    case (reg_addr)
      3'd0:    reg_rdata = {3'b000, sts_fail, sts_coll, sts_nack, sts_done, busy};
      3'd2:    reg_rdata = ctrl_q;
      3'd3:    reg_rdata = cmd_q;
      3'd4:    reg_rdata = addr_q;
      3'd5:    reg_rdata = data0_q;
      3'd6:    reg_rdata = data1_q;
      3'd7:    reg_rdata = buf_q[idx];
      default: reg_rdata = 8'd0;
    endcase
  end

  assign lnk_last = (state == S_RD0 && ty != T_WORD) || (state == S_RD1) ||
                    (state == S_RBLK && last_blk);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && reg_wdata[6] && reg_rdata[0] == 1'b0 && !busy) |=> busy); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_done && !(sts_wr && reg_wdata[1])) |=> sts_done); // R2
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_fail && !(sts_wr && reg_wdata[4])) |=> sts_fail); // R3
  AST_FIRST_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lnk_req) |-> (lnk_op == 2'd0)); // R4
  AST_LAST_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && lnk_last) |-> (lnk_op == 2'd2)); // R6
  AST_IDX_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2) |=> (idx == '0)); // R10
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd4) |=> $stable(addr_q)); // R12
endmodule

// File: tb/smb_host_seq_tb.sv
module smb_host_seq_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic lnk_req, lnk_last;
  logic [1:0] lnk_op;
  logic [7:0] lnk_wbyte;
  logic lnk_done = 0, lnk_ack = 0, lnk_lost = 0;
  logic [7:0] lnk_rbyte = 0;

  int checks = 0, fails = 0;
  int exp_q[$];
  int rq[$];
  int op_idx = 0, nack_at = -1, lost_at = -1;
  int lat = 0;
  bit got = 0;

  always #2 clk = ~clk;

  smb_host_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lnk_req(lnk_req), .lnk_op(lnk_op),
    .lnk_wbyte(lnk_wbyte), .lnk_last(lnk_last), .lnk_done(lnk_done), .lnk_ack(lnk_ack),
    .lnk_lost(lnk_lost), .lnk_rbyte(lnk_rbyte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int E(input int op, input int last, input int b);
    return (op << 9) | (last << 8) | b;
  endfunction

  // link model: checks each request against the expected list, answers after a fixed delay
  always @(negedge clk) begin
    if (lnk_done) lnk_done = 0;
    if (got) begin
      lat--;
      if (lat == 0) begin lnk_done = 1; got = 0; end
    end else if (lnk_req && rst_n) begin
      int code;
      code = E(int'(lnk_op), int'(lnk_last), int'(lnk_wbyte));
      if (exp_q.size() == 0) chk("R5 unexpected link request", code, -1);
      else chk("R4-op link request", code, exp_q.pop_front());
      lnk_ack  = (op_idx != nack_at);
      lnk_lost = (op_idx == lost_at);
      lnk_rbyte = (lnk_op == 2'd2 && rq.size() > 0) ? 8'(rq.pop_front()) : 8'h00;
      op_idx++;
      got = 1;
      lat = 2;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic setup(input logic [7:0] ad, input logic [7:0] cm, input logic [7:0] d0,
                       input logic [7:0] d1);
    wr(3'd4, ad); wr(3'd3, cm); wr(3'd5, d0); wr(3'd6, d1); wr(3'd0, 8'h1F);
    op_idx = 0; nack_at = -1; lost_at = -1;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(3'd0, s);
      if (s[0] == 1'b0) return;
    end
    chk("R1 busy never cleared", 1, 0);
  endtask

  task automatic run(input logic [7:0] ty_bits, input string tag);
    wr(3'd2, ty_bits | 8'h40);
    wait_idle();
    repeat (4) @(negedge clk);
    chk({tag, " all link requests seen"}, exp_q.size(), 0);
  endtask

  logic [7:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, v); chk("R13 reset status", v, 8'h00);
    rd(3'd2, v); chk("R13 reset control", v, 8'h00);
    rd(3'd4, v); chk("R13 reset address", v, 8'h00);

    // quick write
    setup(8'hA0, 8'h00, 8'h00, 8'h00);
    exp_q = '{E(0,0,8'hA0), E(3,0,0)};
    run(8'h00, "R5 quick");
    rd(3'd0, v); chk("R2 done after quick", v, 8'h02);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R2 write 0 keeps done", v, 8'h02);
    wr(3'd0, 8'h02); rd(3'd0, v); chk("R2 write 1 clears done", v, 8'h00);

    // byte write / read
    setup(8'hA0, 8'h3C, 8'h00, 8'h00);
    exp_q = '{E(0,0,8'hA0), E(1,0,8'h3C), E(3,0,0)};
    run(8'h04, "R6 byte write");
    setup(8'hA1, 8'h3C, 8'h00, 8'h00);
    exp_q = '{E(0,0,8'hA1), E(2,1,0), E(3,0,0)};
    rq = '{8'h5A};
    run(8'h04, "R6 byte read");
    rd(3'd5, v); chk("R6 byte read data0", v, 8'h5A);

    // byte-data write, word read, word write
    setup(8'h84, 8'h11, 8'h22, 8'h00);
    exp_q = '{E(0,0,8'h84), E(1,0,8'h11), E(1,0,8'h22), E(3,0,0)};
    run(8'h08, "R7 byte-data write");
    setup(8'h85, 8'h07, 8'h00, 8'h00);
    exp_q = '{E(0,0,8'h84), E(1,0,8'h07), E(0,0,8'h85), E(2,0,0), E(2,1,0), E(3,0,0)};
    rq = '{8'h34, 8'h12};
    run(8'h0C, "R7 word read");
    rd(3'd5, v); chk("R7 word read low in data0", v, 8'h34);
    rd(3'd6, v); chk("R7 word read high in data1", v, 8'h12);
    rd(3'd0, v); chk("R4 status after word read", v, 8'h02);
    setup(8'h84, 8'h09, 8'hCD, 8'hAB);
    exp_q = '{E(0,0,8'h84), E(1,0,8'h09), E(1,0,8'hCD), E(1,0,8'hAB), E(3,0,0)};
    run(8'h0C, "R7 word write");

    // block write
    rd(3'd2, v);
    wr(3'd7, 8'h10); wr(3'd7, 8'h20); wr(3'd7, 8'h30);
    setup(8'h84, 8'h40, 8'h03, 8'h00);
    exp_q = '{E(0,0,8'h84), E(1,0,8'h40), E(1,0,8'h03), E(1,0,8'h10), E(1,0,8'h20),
              E(1,0,8'h30), E(3,0,0)};
    run(8'h14, "R8 block write");
    rd(3'd0, v); chk("R8 block write done", v, 8'h02);
    setup(8'h84, 8'h40, 8'h00, 8'h00);
    run(8'h14, "R8 block count 0");
    rd(3'd0, v); chk("R8 block count 0 failed", v, 8'h10);
    setup(8'h84, 8'h40, 8'd33, 8'h00);
    run(8'h14, "R8 block count 33");
    rd(3'd0, v); chk("R8 block count 33 failed", v, 8'h10);

    // block read
    setup(8'h85, 8'h41, 8'h00, 8'h00);
    exp_q = '{E(0,0,8'h84), E(1,0,8'h41), E(0,0,8'h85), E(2,0,0), E(2,0,0), E(2,1,0),
              E(3,0,0)};
    rq = '{8'h02, 8'hAA, 8'hBB};
    run(8'h14, "R9 block read");
    rd(3'd5, v); chk("R9 block read count in data0", v, 8'h02);
    rd(3'd2, v);
    rd(3'd7, v); chk("R10 first block byte", v, 8'hAA);
    rd(3'd7, v); chk("R10 second block byte", v, 8'hBB);
    rd(3'd2, v);
    rd(3'd7, v); chk("R10 rewind to first byte", v, 8'hAA);
    setup(8'h85, 8'h41, 8'h00, 8'h00);
    exp_q = '{E(0,0,8'h84), E(1,0,8'h41), E(0,0,8'h85), E(2,0,0), E(3,0,0)};
    rq = '{8'h00};
    run(8'h14, "R9 block read count 0");
    rd(3'd0, v); chk("R9 bad received count failed", v, 8'h10);

    // invalid types
    setup(8'hA0, 8'h00, 8'h00, 8'h00);
    run(8'h10, "R11 type 100");
    rd(3'd0, v); chk("R11 type 100 failed", v, 8'h10);
    wr(3'd0, 8'h1F);
    run(8'h1C, "R11 type 111");
    rd(3'd0, v); chk("R11 type 111 failed", v, 8'h10);

    // no acknowledge and arbitration loss
    setup(8'hA0, 8'h00, 8'h00, 8'h00);
    nack_at = 0;
    exp_q = '{E(0,0,8'hA0), E(3,0,0)};
    run(8'h00, "R3 address nack");
    rd(3'd0, v); chk("R3 nack status", v, 8'h04);
    setup(8'hA0, 8'h3C, 8'h00, 8'h00);
    lost_at = 1;
    exp_q = '{E(0,0,8'hA0), E(1,0,8'h3C)};
    run(8'h04, "R3 arbitration loss");
    rd(3'd0, v); chk("R3 collision status", v, 8'h08);
    wr(3'd0, 8'h08); rd(3'd0, v); chk("R3 collision cleared by 1", v, 8'h00);

    // writes while busy are ignored
    setup(8'hA0, 8'h3C, 8'h55, 8'h00);
    exp_q = '{E(0,0,8'hA0), E(1,0,8'h3C), E(3,0,0)};
    wr(3'd2, 8'h44);
    rd(3'd0, v); chk("R1 busy after start", int'(v[0]), 1);
    wr(3'd4, 8'hEE);
    wr(3'd2, 8'h40);
    wr(3'd5, 8'h99);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R12 only one transaction ran", exp_q.size(), 0);
    rd(3'd4, v); chk("R12 address kept", v, 8'hA0);
    rd(3'd5, v); chk("R12 data0 kept", v, 8'h55);
    rd(3'd2, v); chk("R13 control readback", v, 8'h04);
    rd(3'd1, v); chk("R13 offset 1 reads 0", v, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule